// File: doc/BRIEF.md
# Indexed Palette Lookup with Byte-Lane Register Port

This block holds a 256-entry colour lookup table of 24-bit RGB values and serves two clients. A processor reaches it through a narrow register port. One address register selects a table entry or an internal control register. Three successive accesses to a colour-map register move the red, green and blue bytes of that entry. A control register reaches a small bank of mask and overlay registers that share the same address register. Every byte travels in the top lane of the 32-bit bus.

The second client is the video path. Each cycle it presents an 8-bit pixel index. The block ANDs that index with the read mask and returns the matching RGB triple on a registered output one cycle later. Colour writes are staged until the blue byte arrives, so the video path never sees an entry with only some of its components new.

Top module: `clut_port`

## Requirements
- R1: A write with `acc_sel` = 0 (address) loads the index from `acc_wdata[31:24]` and returns the component counter to red. A read with `acc_sel` = 0 returns the index in bits 31:24, with zeros below.
- R2: Three colour-map accesses with `acc_sel` = 1, taken as writes, deliver red, green and blue in that order from bits 31:24. The entry takes all three bytes together on the blue write. An unfinished sequence, cut short by an address write, leaves the entry unchanged.
- R3: Any colour-map access, read or write, made while the counter is at blue advances the index by one, wrapping from 255 to 0, and returns the counter to red.
- R4: Colour-map reads return the bytes of the addressed entry in red, green, blue order, in bits 31:24, with zeros below.
- R5: A write with `acc_sel` = 2 (control) reaches the control bank when the index is 4 to 7: 4 is the read mask, 5 the blink mask, 6 overlay control and 7 overlay blink. At any other index the write is ignored. A control read returns the selected register in bits 31:24, or zero when the index is outside 4 to 7.
- R6: After reset, the index is 0, the counter is at red, the read mask is 0xFF, the blink mask is 0x00, overlay control is 0x73 and overlay blink is 0x00.
- R7: `pix_rgb` equals the entry at (`pix_idx` AND read mask) one clock after `pix_idx` is presented. Red is in bits 23:16, green in 15:8 and blue in 7:0.
- R8: `acc_sel` = 3 is reserved. Writes to it change nothing, reads of it return zero, and accesses to it do not step the component counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access strobe, one access per cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 2 | 0 address, 1 colour map, 2 control, 3 reserved |
| acc_wdata | input | 32 | Write data, byte in bits 31:24 |
| acc_rdata | output | 32 | Read data for the current selection, byte in bits 31:24 |
| pix_idx | input | 8 | Pixel index from the video path |
| pix_rgb | output | 24 | Registered RGB lookup result |

## Verification
The assertions assume that `acc_en` stays low while reset is held, and that only one access is presented per cycle. The bench drives every access for one clock and releases it at the falling edge, and it starts accesses only after reset is released. The counter-advance property also assumes that a blue step and an address load never arrive together, which follows from the single-access port.

// File: rtl/clut_pkg.sv
package clut_pkg;
   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_CMAP = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_RSVD = 2'd3
   } port_sel_e;

   typedef enum logic [1:0] {
      COMP_R = 2'd0,
      COMP_G = 2'd1,
      COMP_B = 2'd2
   } comp_e;
endpackage

// File: rtl/clut_seq.sv
module clut_seq
   import clut_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             addr_wr,
   input  logic [IDX_W-1:0] load_val,
   input  logic             cmap_step,
   output logic [IDX_W-1:0] idx,
   output comp_e            comp,
   output logic             last_comp
);
   assign last_comp = cmap_step && (comp == COMP_B);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx  <= '0;
         comp <= COMP_R;
      end else if (addr_wr) begin
         idx  <= load_val;
         comp <= COMP_R;
      end else if (cmap_step) begin
         case (comp)
            COMP_R:  comp <= COMP_G;
            COMP_G:  comp <= COMP_B;
            default: begin
               comp <= COMP_R;
               idx  <= idx + 1'b1;
            end
         endcase
      end
   end

   AST_COMP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      comp != 2'd3); // R3
   AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      addr_wr |=> (idx == $past(load_val)) && (comp == COMP_R)); // R1
   AST_INDEX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmap_step && comp == COMP_B && !addr_wr) |=>
         (idx == IDX_W'($past(idx) + 1'b1)) && (comp == COMP_R)); // R3
endmodule

// File: rtl/clut_ctrl_bank.sv
module clut_ctrl_bank #(
   parameter int                       IDX_W  = 8,
   parameter int                       COMP_W = 8,
   parameter int                       BASE   = 4,
   parameter int                       NREG   = 4,
   parameter logic [NREG*COMP_W-1:0]   INIT   = {8'h00, 8'h73, 8'h00, 8'hFF}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [IDX_W-1:0]  sel_idx,
   input  logic [COMP_W-1:0] wdata,
   output logic              hit,
   output logic [COMP_W-1:0] rd_val,
   output logic [COMP_W-1:0] mask
);
   localparam int OFF_W = (NREG > 1) ? $clog2(NREG) : 1;

   if (NREG < 1) begin : g_bad_nreg
      $error("clut_ctrl_bank: NREG must be at least 1");
   end

   logic [COMP_W-1:0] regs_q [NREG];
   logic [OFF_W-1:0]  off;

   assign hit = (int'(sel_idx) >= BASE) && (int'(sel_idx) < BASE + NREG);
   assign off = OFF_W'(int'(sel_idx) - BASE);

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs_q[g] <= INIT[g*COMP_W +: COMP_W];
         else if (wr && hit && (off == OFF_W'(g)))
            regs_q[g] <= wdata;
      end
   end

   assign rd_val = hit ? regs_q[off] : '0;
   assign mask   = regs_q[0];

   AST_CTRL_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !hit) |=> $stable(mask)); // R5
   AST_CTRL_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && int'(sel_idx) == BASE) |=> mask == $past(wdata)); // R5
endmodule

// File: rtl/clut_store.sv
module clut_store
   import clut_pkg::*;
#(
   parameter int IDX_W   = 8,
   parameter int COMP_W  = 8,
   parameter bit MASK_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [3*COMP_W-1:0] wr_rgb,
   input  logic [IDX_W-1:0]    rd_idx,
   input  comp_e               rd_comp,
   output logic [COMP_W-1:0]   rd_byte,
   input  logic [IDX_W-1:0]    pix_idx,
   input  logic [COMP_W-1:0]   mask,
   output logic [3*COMP_W-1:0] pix_rgb
);
   localparam int DEPTH = 1 << IDX_W;
   localparam int RGB_W = 3 * COMP_W;

   logic [RGB_W-1:0] mem [DEPTH];
   logic [IDX_W-1:0] look_idx;
   logic [RGB_W-1:0] rd_word;

   if (MASK_EN) begin : g_mask
      if (COMP_W >= IDX_W) begin : g_wide
         assign look_idx = pix_idx & mask[IDX_W-1:0];
      end else begin : g_narrow
         assign look_idx = pix_idx & IDX_W'(mask);
      end
   end else begin : g_nomask
      assign look_idx = pix_idx;
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_rgb;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pix_rgb <= '0;
      else        pix_rgb <= mem[look_idx];
   end

   assign rd_word = mem[rd_idx];
   always_comb begin
      case (rd_comp)
         COMP_R:  rd_byte = rd_word[RGB_W-1 -: COMP_W];
         COMP_G:  rd_byte = rd_word[2*COMP_W-1 -: COMP_W];
         default: rd_byte = rd_word[COMP_W-1:0];
      endcase
   end
endmodule

// File: rtl/clut_port.sv
module clut_port
   import clut_pkg::*;
#(
   parameter int BUS_W   = 32,
   parameter int COMP_W  = 8,
   parameter int IDX_W   = 8,
   parameter bit MASK_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_en,
   input  logic                acc_we,
   input  logic [1:0]          acc_sel,
   input  logic [BUS_W-1:0]    acc_wdata,
   output logic [BUS_W-1:0]    acc_rdata,
   input  logic [IDX_W-1:0]    pix_idx,
   output logic [3*COMP_W-1:0] pix_rgb
);
   localparam int LANE_SH = BUS_W - COMP_W;
   localparam int IDX_SH  = BUS_W - IDX_W;

   if (BUS_W < COMP_W || BUS_W < IDX_W) begin : g_bad_bus
      $error("clut_port: BUS_W narrower than a component or an index");
   end

   port_sel_e         sel;
   logic [COMP_W-1:0] lane;
   logic              addr_wr, cmap_step, cmap_wr, ctrl_wr, last_comp, ctrl_hit;
   logic [IDX_W-1:0]  idx;
   comp_e             comp;
   logic [COMP_W-1:0] stage_r, stage_g, rd_byte, ctrl_val, rd_mask;

   assign sel       = port_sel_e'(acc_sel);
   assign lane      = acc_wdata[BUS_W-1 -: COMP_W];
   assign addr_wr   = acc_en && acc_we && (sel == SEL_ADDR);
   assign cmap_step = acc_en && (sel == SEL_CMAP);
   assign cmap_wr   = cmap_step && acc_we;
   assign ctrl_wr   = acc_en && acc_we && (sel == SEL_CTRL);

   clut_seq #(.IDX_W(IDX_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr),
      .load_val(acc_wdata[BUS_W-1 -: IDX_W]), .cmap_step(cmap_step),
      .idx(idx), .comp(comp), .last_comp(last_comp)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_r <= '0;
         stage_g <= '0;
      end else if (cmap_wr) begin
         if (comp == COMP_R) stage_r <= lane;
         if (comp == COMP_G) stage_g <= lane;
      end
   end

   clut_ctrl_bank #(.IDX_W(IDX_W), .COMP_W(COMP_W)) bank_i (
      .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .sel_idx(idx),
      .wdata(lane), .hit(ctrl_hit), .rd_val(ctrl_val), .mask(rd_mask)
   );

   clut_store #(.IDX_W(IDX_W), .COMP_W(COMP_W), .MASK_EN(MASK_EN)) store_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cmap_wr && last_comp), .wr_idx(idx),
      .wr_rgb({stage_r, stage_g, lane}),
      .rd_idx(idx), .rd_comp(comp), .rd_byte(rd_byte),
      .pix_idx(pix_idx), .mask(rd_mask), .pix_rgb(pix_rgb)
   );

   always_comb begin
      case (sel)
         SEL_ADDR: acc_rdata = BUS_W'(idx) << IDX_SH;
         SEL_CMAP: acc_rdata = BUS_W'(rd_byte) << LANE_SH;
         SEL_CTRL: acc_rdata = ctrl_hit ? (BUS_W'(ctrl_val) << LANE_SH) : '0;
         default:  acc_rdata = '0;
      endcase
   end

   AST_RSVD_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && sel == SEL_RSVD) |=> $stable(idx) && $stable(comp)); // R8
   AST_PARTIAL_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmap_wr && comp == COMP_R) |=> stage_r == $past(lane)); // R2
endmodule

// File: tb/clut_port_tb_top.sv
module clut_port_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_en = 1'b0;
   logic        acc_we = 1'b0;
   logic [1:0]  acc_sel = 2'd0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] acc_rdata;
   logic [7:0]  pix_idx = '0;
   logic [23:0] pix_rgb;

   int applied = 0;
   int fails   = 0;
   bit done    = 1'b0;

   // each vector: {index, red, green, blue}
   localparam logic [31:0] VEC [8] = '{
      32'h01_112233, 32'h0F_A0B0C0, 32'h1F_0A0B0C, 32'h40_FF0000,
      32'h7E_00FF00, 32'h80_0000FF, 32'hC3_5A5AA5, 32'hFE_123456
   };

   always #(CLK_PERIOD/2) clk = ~clk;

   clut_port dut_i (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
      .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .pix_idx(pix_idx), .pix_rgb(pix_rgb)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      applied++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic acc(input logic we, input logic [1:0] sel, input logic [7:0] b,
                      output logic [31:0] rd);
      @(negedge clk);
      acc_en = 1'b1; acc_we = we; acc_sel = sel; acc_wdata = {b, 24'h5A5A5A};
      #1 rd = acc_rdata;
      @(posedge clk);
      #1 acc_en = 1'b0; acc_we = 1'b0;
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] b);
      logic [31:0] d;
      acc(1'b1, sel, b, d);
   endtask

   task automatic rd_chk(input string req, input logic [1:0] sel, input logic [7:0] exp);
      logic [31:0] d;
      acc(1'b0, sel, 8'h00, d);
      chk(req, d, {exp, 24'h0});
   endtask

   task automatic pix_chk(input string req, input logic [7:0] p, input logic [23:0] exp);
      @(negedge clk);
      pix_idx = p;
      @(posedge clk);
      #1 chk(req, {8'h0, pix_rgb}, {8'h0, exp});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 chk("R6 pixel reset", {8'h0, pix_rgb}, 32'h0);
      @(negedge clk) rst_n = 1'b1;

      // R6 reset state
      rd_chk("R6 index", 2'd0, 8'h00);
      wr(2'd0, 8'd4); rd_chk("R6 read mask", 2'd2, 8'hFF);
      wr(2'd0, 8'd5); rd_chk("R6 blink mask", 2'd2, 8'h00);
      wr(2'd0, 8'd6); rd_chk("R6 overlay ctrl", 2'd2, 8'h73);
      wr(2'd0, 8'd7); rd_chk("R6 overlay blink", 2'd2, 8'h00);

      // vector table: load, read back, look up
      for (int i = 0; i < 8; i++) begin
         wr(2'd0, VEC[i][31:24]);
         wr(2'd1, VEC[i][23:16]); wr(2'd1, VEC[i][15:8]); wr(2'd1, VEC[i][7:0]);
         rd_chk("R3 index after blue write", 2'd0, VEC[i][31:24] + 8'd1);
         wr(2'd0, VEC[i][31:24]);
         rd_chk("R1 index readback", 2'd0, VEC[i][31:24]);
         rd_chk("R4 red", 2'd1, VEC[i][23:16]);
         rd_chk("R4 green", 2'd1, VEC[i][15:8]);
         rd_chk("R4 blue", 2'd1, VEC[i][7:0]);
         rd_chk("R3 index after blue read", 2'd0, VEC[i][31:24] + 8'd1);
      end
      for (int i = 0; i < 8; i++)
         pix_chk("R7 lookup", VEC[i][31:24], VEC[i][23:0]);

      // R3 wrap from 255 to 0 with auto-increment
      wr(2'd0, 8'hFF);
      wr(2'd1, 8'h01); wr(2'd1, 8'h02); wr(2'd1, 8'h03);
      rd_chk("R3 wrap index", 2'd0, 8'h00);
      wr(2'd1, 8'h04); wr(2'd1, 8'h05); wr(2'd1, 8'h06);
      pix_chk("R3 entry 255", 8'hFF, 24'h010203);
      pix_chk("R3 auto-increment entry 0", 8'h00, 24'h040506);

      // R2 unfinished sequence leaves entry untouched; R1 counter restarts
      wr(2'd0, 8'h30);
      wr(2'd1, 8'h0A); wr(2'd1, 8'h0B); wr(2'd1, 8'h0C);
      wr(2'd0, 8'h30);
      wr(2'd1, 8'h99); wr(2'd1, 8'h98);
      pix_chk("R2 partial not committed", 8'h30, 24'h0A0B0C);
      wr(2'd0, 8'h30);
      wr(2'd1, 8'hAA); wr(2'd1, 8'hBB); wr(2'd1, 8'hCC);
      pix_chk("R1 restart at red", 8'h30, 24'hAABBCC);

      // R8 reserved select
      wr(2'd0, 8'h30);
      rd_chk("R8 setup red", 2'd1, 8'hAA);
      wr(2'd3, 8'h77);
      rd_chk("R8 reserved read zero", 2'd3, 8'h00);
      rd_chk("R8 counter not stepped", 2'd1, 8'hBB);
      rd_chk("R8 index unchanged", 2'd0, 8'h30);

      // R5 control bank decode
      wr(2'd0, 8'd8); wr(2'd2, 8'h55);
      rd_chk("R5 out-of-range read zero", 2'd2, 8'h00);
      wr(2'd0, 8'd3); wr(2'd2, 8'h66);
      rd_chk("R5 below-range read zero", 2'd2, 8'h00);
      wr(2'd0, 8'd4); rd_chk("R5 mask untouched", 2'd2, 8'hFF);
      wr(2'd0, 8'd7); rd_chk("R5 overlay blink untouched", 2'd2, 8'h00);
      wr(2'd0, 8'd6); wr(2'd2, 8'h12);
      rd_chk("R5 overlay ctrl write", 2'd2, 8'h12);
      wr(2'd0, 8'd5); wr(2'd2, 8'h3C);
      rd_chk("R5 blink mask write", 2'd2, 8'h3C);
      wr(2'd0, 8'd4); wr(2'd2, 8'h0F);
      rd_chk("R5 read mask write", 2'd2, 8'h0F);

      // R7 masked lookup: 0x1F & 0x0F selects entry 0x0F
      pix_chk("R7 masked lookup", 8'h1F, 24'hA0B0C0);
      pix_chk("R7 masked lookup high bits", 8'hF1, 24'h112233);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
   end
endmodule